// File: doc/BRIEF.md
# Multicontext Coarse-Grain Processing Element

This block is one 8-bit cell of a coarse-grain reconfigurable array. It does not fetch instructions. A small local store holds sixteen configuration words. An external context index picks one of them in every cycle. The chosen word sets the ALU operation, where each operand comes from, the shift and mask applied to the result, and whether the result is captured in the output register. Changing the index changes the cell's function in the very next cycle, with no reload time. The cell can therefore serve a different step of a larger datapath in each cycle, while a sequencing controller outside the cell drives the index.

The configuration store can be written at any time through a simple port: a slot number, a word and a write strobe. Only the output register carries a value from one context into a later one. Combinational results exist only in the cycle that produced them. The register is fed back as an operand source, so that a later context can use the value.

Top module: `mcpe_cell`

## Requirements
- R1: Reset clears `dout` to zero. It also loads every slot with a no-write pass-through word: op PASS, operand A from `din_a`, operand B from `din_b`, shift 0, mask all ones, capture off. After reset, `dout` therefore stays zero whichever slot is selected.
- R2: A configuration word is 20 bits, laid out from the MSB down as follows:
  - capture enable [19]
  - mask [18:11]
  - shift direction [10]
  - shift amount [9:7]
  - operand-B source [6:5]
  - operand-A source [4:3]
  - opcode [2:0]
- R3: The opcode field selects the ALU operation:
  - 0: A+B, modulo 256
  - 1: A-B, modulo 256
  - 2: A AND B
  - 3: A OR B
  - 4: A XOR B
  - 5: pass A
  - 6 and 7: also pass A
- R4: Each operand source code selects a value: 0 gives `din_a`, 1 gives `din_b`, 2 gives the current output register value (feedback), and 3 gives constant zero.
- R5: The ALU result is shifted by the amount field. Direction 0 shifts left and direction 1 shifts logically right, with zeros filled in. The shifted value is then ANDed with the mask field.
- R6: When the active word has capture enable set, `dout` takes the shifted and masked result at the clock edge. Otherwise `dout` holds its value.
- R7: The slot named by `ctx_sel` controls the datapath in the same cycle. A different slot may be selected in each consecutive cycle, with no idle cycle between them.
- R8: A configuration write lands at the clock edge. If it targets the active slot, the old word still controls that cycle and the new word applies from the next cycle. A write to any other slot leaves the current cycle's result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_sel | input | 4 | Index of the slot controlling this cycle |
| din_a | input | 8 | First data input |
| din_b | input | 8 | Second data input |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | 4 | Slot written when `cfg_we` is high |
| cfg_word | input | 20 | Configuration word to store |
| dout | output | 8 | Registered result |

## Verification
The hardest case to reach is a configuration write to the slot that is active in the same cycle. Both the old and the new word must be visible at the ports in two successive cycles. The bench holds the index on a slot and rewrites that slot in the same cycle with a word that routes the other input. It then checks that `dout` shows the old routing first and the new routing one cycle later. A second sequence writes a different slot during an active cycle and then selects it. Feedback accumulation and cycle-by-cycle index changes show that only the register carries values between contexts.

// File: rtl/mcpe_pkg.sv
package mcpe_pkg;

  localparam int OP_W  = 3;
  localparam int SRC_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_PASS = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } alu_op_e;

  typedef enum logic [SRC_W-1:0] {
    SRC_A    = 2'd0,
    SRC_B    = 2'd1,
    SRC_FB   = 2'd2,
    SRC_ZERO = 2'd3
  } src_e;

endpackage

// File: rtl/mcpe_ctx_store.sv
module mcpe_ctx_store #(
  parameter int N_CTX = 16,
  parameter int CFG_W = 20,
  parameter logic [CFG_W-1:0] RST_WORD = '0,
  localparam int IDX_W = $clog2(N_CTX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CFG_W-1:0] wr_word,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CFG_W-1:0] rd_word
);

  logic [CFG_W-1:0] slots [N_CTX];

  // Slots are cleared on reset, so this is a register file rather than a RAM.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_CTX; i++) slots[i] <= RST_WORD;
    end else if (we) begin
      slots[wr_idx] <= wr_word;
    end
  end

  // The read is asynchronous, so a newly selected slot acts in the same cycle.
  assign rd_word = slots[rd_idx];

  // R8: a word written at one edge is the word read back from that slot after the edge.
  assert_slot_write_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && !$past(rst) && rd_idx == $past(wr_idx)) |-> rd_word == $past(wr_word));

endmodule

// File: rtl/mcpe_opnd_sel.sv
module mcpe_opnd_sel
  import mcpe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  src_e              sel,
  input  logic [DATA_W-1:0] din_a,
  input  logic [DATA_W-1:0] din_b,
  input  logic [DATA_W-1:0] fb,
  output logic [DATA_W-1:0] opnd
);

  always_comb begin
    unique case (sel)
      SRC_A:   opnd = din_a;
      SRC_B:   opnd = din_b;
      SRC_FB:  opnd = fb;
      default: opnd = '0;
    endcase
    // R4: the zero source must never leak data
    if (sel == SRC_ZERO) begin
      assert_zero_src_R4: assert (opnd == '0);
    end
  end

endmodule

// File: rtl/mcpe_alu.sv
module mcpe_alu
  import mcpe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = a;
    endcase
    // R3: a difference plus the subtrahend gives back the minuend
    if (op == OP_SUB) begin
      assert_sub_inverse_R3: assert (DATA_W'(y + b) == a);
    end
  end

endmodule

// File: rtl/mcpe_shmask.sv
module mcpe_shmask #(
  parameter int DATA_W = 8,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  input  logic              shr,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] y
);

  logic [DATA_W-1:0] shifted;

  always_comb begin
    shifted = shr ? (din >> amt) : (din << amt);
    y       = shifted & mask;
    // R5: no bit survives outside the mask
    assert_masked_R5: assert ((y & ~mask) == '0);
  end

endmodule

// File: rtl/mcpe_cell.sv
module mcpe_cell
  import mcpe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int N_CTX  = 16,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int IDX_W = $clog2(N_CTX),
  localparam int CFG_W = 1 + DATA_W + 1 + SH_W + 2 * SRC_W + OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  ctx_sel,
  input  logic [DATA_W-1:0] din_a,
  input  logic [DATA_W-1:0] din_b,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_slot,
  input  logic [CFG_W-1:0]  cfg_word,
  output logic [DATA_W-1:0] dout
);

  typedef struct packed {
    logic              reg_en;
    logic [DATA_W-1:0] mask;
    logic              shr;
    logic [SH_W-1:0]   amt;
    src_e              sel_b;
    src_e              sel_a;
    alu_op_e           op;
  } cfg_t;

  localparam logic [CFG_W-1:0] RST_WORD =
    {1'b0, {DATA_W{1'b1}}, 1'b0, {SH_W{1'b0}}, SRC_B, SRC_A, OP_PASS};

  logic [CFG_W-1:0]  act_word;
  cfg_t              act;
  logic [DATA_W-1:0] dout_q;
  logic [DATA_W-1:0] opnd [2];
  src_e              sel_v [2];
  logic [DATA_W-1:0] alu_y;
  logic [DATA_W-1:0] shm_y;

  mcpe_ctx_store #(
    .N_CTX    (N_CTX),
    .CFG_W    (CFG_W),
    .RST_WORD (RST_WORD)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .wr_idx  (cfg_slot),
    .wr_word (cfg_word),
    .rd_idx  (ctx_sel),
    .rd_word (act_word)
  );

  assign act      = cfg_t'(act_word);
  assign sel_v[0] = act.sel_a;
  assign sel_v[1] = act.sel_b;

  for (genvar k = 0; k < 2; k++) begin : g_opnd
    mcpe_opnd_sel #(.DATA_W(DATA_W)) u_sel (
      .sel   (sel_v[k]),
      .din_a (din_a),
      .din_b (din_b),
      .fb    (dout_q),
      .opnd  (opnd[k])
    );
  end

  mcpe_alu #(.DATA_W(DATA_W)) u_alu (
    .op (act.op),
    .a  (opnd[0]),
    .b  (opnd[1]),
    .y  (alu_y)
  );

  mcpe_shmask #(.DATA_W(DATA_W)) u_shm (
    .din  (alu_y),
    .amt  (act.amt),
    .shr  (act.shr),
    .mask (act.mask),
    .y    (shm_y)
  );

  always_ff @(posedge clk) begin
    if (rst)             dout_q <= '0;
    else if (act.reg_en) dout_q <= shm_y;
  end

  assign dout = dout_q;

  // R6: after a capturing cycle the output shows what the shift/mask stage produced
  assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(act.reg_en) && !$past(rst)) |-> dout == $past(shm_y));

  // R6: a non-capturing cycle leaves the output untouched
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(act.reg_en) && !$past(rst)) |-> $stable(dout));

endmodule

// File: tb/test_mcpe_cell.sv
`timescale 1ns/1ps
module test_mcpe_cell;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ctx_sel = '0;
  logic [7:0]  din_a = '0;
  logic [7:0]  din_b = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_slot = '0;
  logic [19:0] cfg_word = '0;
  logic [7:0]  dout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mcpe_cell i_mcpe_cell (
    .clk(clk), .rst(rst), .ctx_sel(ctx_sel), .din_a(din_a), .din_b(din_b),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_word(cfg_word), .dout(dout)
  );

  // R2 layout: capture[19] mask[18:11] dir[10] amt[9:7] srcB[6:5] srcA[4:3] op[2:0]
  function automatic logic [19:0] mk(input bit re, input logic [7:0] m, input bit shr,
                                     input logic [2:0] amt, input logic [1:0] sb,
                                     input logic [1:0] sa, input logic [2:0] op);
    return {re, m, shr, amt, sb, sa, op};
  endfunction

  function automatic logic [7:0] ref_alu(input logic [2:0] op, input logic [7:0] a,
                                         input logic [7:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      default: return a;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: dout=%h expected=%h", req, got, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge, after the capture edge.
  task automatic apply(input logic [3:0] c, input logic [7:0] a, input logic [7:0] b);
    ctx_sel = c; din_a = a; din_b = b;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] s, input logic [19:0] w);
    cfg_we = 1'b1; cfg_slot = s; cfg_word = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset output", dout, 8'h00);
    for (int c = 0; c < 16; c++) begin
      apply(4'(c), 8'h5A, 8'h33);
      chk("R1 slot no-write after reset", dout, 8'h00);
    end
  endtask

  task automatic t_alu;
    logic [7:0] pa [4] = '{8'hC8, 8'h05, 8'hFF, 8'h3C};
    logic [7:0] pb [4] = '{8'h64, 8'h09, 8'h01, 8'hA5};
    for (int op = 0; op < 8; op++) begin
      wr(4'd0, mk(1, 8'hFF, 0, 3'd0, 2'd1, 2'd0, 3'(op)));
      for (int p = 0; p < 4; p++) begin
        apply(4'd0, pa[p], pb[p]);
        chk("R3 alu op (R2 fields)", dout, ref_alu(3'(op), pa[p], pb[p]));
      end
    end
  endtask

  task automatic t_sources;
    wr(4'd2, mk(1, 8'hFF, 0, 3'd0, 2'd1, 2'd0, 3'd5));
    wr(4'd3, mk(1, 8'hFF, 0, 3'd0, 2'd3, 2'd2, 3'd0));
    wr(4'd4, mk(1, 8'hFF, 0, 3'd0, 2'd2, 2'd1, 3'd0));
    wr(4'd5, mk(1, 8'hFF, 0, 3'd0, 2'd0, 2'd3, 3'd1));
    wr(4'd12, mk(1, 8'hFF, 0, 3'd0, 2'd0, 2'd2, 3'd0));
    apply(4'd2, 8'h11, 8'hEE);
    chk("R4 source A", dout, 8'h11);
    apply(4'd3, 8'hAA, 8'hBB);
    chk("R4 feedback plus zero", dout, 8'h11);
    apply(4'd4, 8'hAA, 8'h22);
    chk("R4 B plus feedback", dout, 8'h33);
    apply(4'd5, 8'h01, 8'h77);
    chk("R4 zero minus A", dout, 8'hFF);
    apply(4'd2, 8'h11, 8'h00);
    for (int k = 1; k <= 3; k++) begin
      apply(4'd12, 8'h05, 8'h00);
      chk("R4 R7 feedback accumulate", dout, 8'(8'h11 + 5 * k));
    end
  endtask

  task automatic t_shift;
    logic [7:0] va [5] = '{8'h96, 8'h96, 8'h96, 8'hFF, 8'h81};
    bit         dr [5] = '{0, 1, 0, 1, 0};
    logic [2:0] am [5] = '{3'd3, 3'd3, 3'd0, 3'd7, 3'd7};
    logic [7:0] mm [5] = '{8'hFF, 8'hFF, 8'h0F, 8'hFF, 8'hFF};
    logic [7:0] ex [5] = '{8'hB0, 8'h12, 8'h06, 8'h01, 8'h80};
    for (int i = 0; i < 5; i++) begin
      wr(4'd1, mk(1, mm[i], dr[i], am[i], 2'd1, 2'd0, 3'd5));
      apply(4'd1, va[i], 8'h00);
      chk("R5 shift and mask", dout, ex[i]);
    end
    wr(4'd1, mk(1, 8'hF0, 1, 3'd1, 2'd1, 2'd0, 3'd0));
    apply(4'd1, 8'h40, 8'h20);
    chk("R5 shift after alu", dout, 8'h30);
  endtask

  task automatic t_hold_switch;
    wr(4'd7, mk(1, 8'hFF, 0, 3'd0, 2'd1, 2'd0, 3'd5));
    wr(4'd8, mk(1, 8'hFF, 0, 3'd0, 2'd1, 2'd1, 3'd5));
    wr(4'd9, mk(1, 8'hFF, 0, 3'd0, 2'd1, 2'd0, 3'd1));
    wr(4'd6, mk(0, 8'hFF, 0, 3'd0, 2'd1, 2'd0, 3'd4));
    apply(4'd7, 8'h30, 8'h10);
    chk("R7 switch to slot 7", dout, 8'h30);
    apply(4'd8, 8'h30, 8'h10);
    chk("R7 switch to slot 8", dout, 8'h10);
    apply(4'd9, 8'h30, 8'h10);
    chk("R7 switch to slot 9", dout, 8'h20);
    apply(4'd7, 8'h99, 8'h10);
    chk("R7 back to slot 7", dout, 8'h99);
    apply(4'd6, 8'h01, 8'h02);
    chk("R6 capture off holds", dout, 8'h99);
    apply(4'd6, 8'hF0, 8'h0F);
    chk("R6 capture off holds again", dout, 8'h99);
  endtask

  task automatic t_live_write;
    wr(4'd10, mk(1, 8'hFF, 0, 3'd0, 2'd1, 2'd0, 3'd5));
    apply(4'd10, 8'h44, 8'h77);
    chk("R8 slot 10 initial", dout, 8'h44);
    ctx_sel = 4'd10; din_a = 8'h45; din_b = 8'h77;
    cfg_we = 1'b1; cfg_slot = 4'd10; cfg_word = mk(1, 8'hFF, 0, 3'd0, 2'd1, 2'd1, 3'd5);
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R8 active slot write uses old word", dout, 8'h45);
    @(negedge clk);
    chk("R8 active slot write applies next cycle", dout, 8'h77);
    din_b = 8'h12;
    cfg_we = 1'b1; cfg_slot = 4'd11; cfg_word = mk(1, 8'hFF, 0, 3'd0, 2'd1, 2'd0, 3'd4);
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R8 other slot write leaves result", dout, 8'h12);
    apply(4'd11, 8'h0F, 8'hF0);
    chk("R8 other slot write landed", dout, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_alu();
    t_sources();
    t_shift();
    t_hold_switch();
    t_live_write();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule